// File: doc/BRIEF.md
# Power-down entry and wake-up sequencer

This block decides when a chip drops into its low-power state and how it returns to normal running. Software programs a small control word: a power-down request, a separate entry-permit bit, a choice between a short and a long settling delay, and a wake-interrupt enable. The block enters power-down only when the request and the permit are both set and the CPU reports that it is idle, waiting for an interrupt.

While powered down, the system clock enable is held low. A pulse on any of the three wake inputs (GPIO, watchdog, real-time clock) moves the block into a settling phase. During that phase the clock stays gated for 60 µs or 200 µs, counted on the always-on reference clock, so that the core regulator can settle. At the same moment the hardware clears the request bit and sets a sticky wake flag. Software clears the flag by writing 1 to it. The interrupt output is a level: it is high while the flag and the enable are both set.

The control word is plain register access: a write strobe with write data, and read data that is always valid. There is no streaming data path, so there is no valid/ready handshake.

Top module: `pdseq_top`

## Requirements
- R1: After reset the control word reads 0, `sys_clk_en` is 1, and `pd_active` and `wake_irq` are 0. The field positions in the control word are: bit 0 power-down request, bit 1 entry permit, bit 2 long-delay select, bit 3 wake-interrupt enable, bit 4 wake flag.
- R2: `pd_active` rises only after the request and the permit are both 1 and `cpu_idle` is 1. With `cpu_idle` at 0 the block stays out of power-down.
- R3: A request written while the entry permit is 0 never causes entry, even with `cpu_idle` high.
- R4: In power-down, a one-cycle pulse on any of `wake_gpio`, `wake_wdt` or `wake_rtc` ends power-down. Without such a pulse the block stays down. A wake pulse seen in normal running has no effect on the flag or on the clock enable.
- R5: After the wake edge, `sys_clk_en` stays low for exactly REF_HZ×60/10^6 reference cycles when the long-delay select is 0, and for exactly REF_HZ×200/10^6 cycles when it is 1.
- R6: `sys_clk_en` is 0 in power-down and during settling, and 1 at all other times.
- R7: On leaving power-down the wake flag (bit 4) is set and the request bit (bit 0) is cleared by hardware. A hardware set or clear takes priority over a software write in the same cycle.
- R8: Writing 1 to bit 4 clears the wake flag. Writing 0 to bit 4 leaves it unchanged.
- R9: `wake_irq` equals the wake flag AND the wake-interrupt enable, at all times.
- R10: A wake pulse during settling does not restart or lengthen the settle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Control-word write strobe |
| cfg_wr_data | input | 5 | Control-word write data (bit 4 is write-1-to-clear) |
| cfg_rd_data | output | 5 | Current control word |
| cpu_idle | input | 1 | CPU is idle, waiting for an interrupt |
| wake_gpio | input | 1 | GPIO wake pulse |
| wake_wdt | input | 1 | Watchdog wake pulse |
| wake_rtc | input | 1 | Real-time-clock wake pulse |
| sys_clk_en | output | 1 | System clock enable (0 means gated) |
| pd_active | output | 1 | Block is in power-down |
| wake_irq | output | 1 | Level wake interrupt |

## Verification
Most wrong internal states show up at the ports at once. A wrong settle count changes how many cycles `sys_clk_en` stays low after the wake edge, and the bench counts that number exactly. A lost hardware clear of the request bit shows as an immediate re-entry, with `pd_active` rising again within two cycles of the clock release. It also shows on the next read of bit 0. A flag that is set or cleared at the wrong time changes `wake_irq` in the same cycle, because that output is combinational on the registered flag.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  localparam int unsigned CFG_W = 5;

  typedef enum logic [1:0] {
    ST_RUN        = 2'd0,
    ST_WAIT_ENTRY = 2'd1,
    ST_DOWN       = 2'd2,
    ST_SETTLE     = 2'd3
  } pd_state_t;

  // Packed MSB first: wake_flag is bit 4, pd_req is bit 0.
  typedef struct packed {
    logic wake_flag;
    logic irq_en;
    logic long_dly;
    logic entry_ok;
    logic pd_req;
  } pd_cfg_t;
endpackage

// File: rtl/pdseq_regs.sv
module pdseq_regs
  import pdseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             wake_evt,
  output pd_cfg_t          cfg
);
  pd_cfg_t wd;
  assign wd = pd_cfg_t'(wr_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      if (wr_en) begin
        cfg.pd_req   <= wd.pd_req;
        cfg.entry_ok <= wd.entry_ok;
        cfg.long_dly <= wd.long_dly;
        cfg.irq_en   <= wd.irq_en;
        if (wd.wake_flag) cfg.wake_flag <= 1'b0;
      end
      // A hardware event wins over a software write in the same cycle.
      if (wake_evt) begin
        cfg.pd_req    <= 1'b0;
        cfg.wake_flag <= 1'b1;
      end
    end
  end

  assert_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (cfg.wake_flag && !cfg.pd_req));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wd.wake_flag && !wake_evt) |=> !cfg.wake_flag);

  assert_w0_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wd.wake_flag && cfg.wake_flag) |=> cfg.wake_flag);
endmodule

// File: rtl/pdseq_timer.sv
module pdseq_timer #(
  parameter int unsigned SHORT_CYC = 60,
  parameter int unsigned LONG_CYC  = 200,
  localparam int unsigned MAX_CYC  = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC,
  localparam int unsigned CW       = $clog2(MAX_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  input  logic run,
  output logic done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= long_sel ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = (cnt == '0);

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

  assert_load_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == (long_sel_q ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1))));

  // Checker-side copy of the select sampled with the load.
  logic long_sel_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) long_sel_q <= 1'b0;
    else if (load) long_sel_q <= long_sel;
  end
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_req,
  input  logic      entry_ok,
  input  logic      cpu_idle,
  input  logic      any_wake,
  input  logic      settle_done,
  output pd_state_t state,
  output logic      wake_evt,
  output logic      settle_run
);
  pd_state_t nxt;
  logic      armed;

  assign armed = pd_req && entry_ok;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:        if (armed) nxt = ST_WAIT_ENTRY;
      ST_WAIT_ENTRY: if (!armed) nxt = ST_RUN;
                     else if (cpu_idle) nxt = ST_DOWN;
      ST_DOWN:       if (any_wake) nxt = ST_SETTLE;
      ST_SETTLE:     if (settle_done) nxt = ST_RUN;
      default:       nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  assign wake_evt   = (state == ST_DOWN) && any_wake;
  assign settle_run = (state == ST_SETTLE);

  assert_entry_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_DOWN) ##1 (state == ST_DOWN) |-> $past(cpu_idle && pd_req && entry_ok));

  assert_no_entry_unpermitted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_DOWN && !entry_ok) |=> (state != ST_DOWN));

  assert_wake_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOWN && any_wake) |=> (state == ST_SETTLE));

  assert_stay_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOWN && !any_wake) |=> (state == ST_DOWN));
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int unsigned REF_HZ   = 1_000_000,
  parameter int unsigned SHORT_US = 60,
  parameter int unsigned LONG_US  = 200,
  localparam int unsigned SHORT_CYC = (REF_HZ / 1000) * SHORT_US / 1000,
  localparam int unsigned LONG_CYC  = (REF_HZ / 1000) * LONG_US / 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  input  logic             cpu_idle,
  input  logic             wake_gpio,
  input  logic             wake_wdt,
  input  logic             wake_rtc,
  output logic             sys_clk_en,
  output logic             pd_active,
  output logic             wake_irq
);
  pd_cfg_t   cfg;
  pd_state_t state;
  logic      wake_evt;
  logic      settle_run;
  logic      settle_done;
  logic      any_wake;

  assign any_wake = wake_gpio | wake_wdt | wake_rtc;

  pdseq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_wr_en),
    .wr_data  (cfg_wr_data),
    .wake_evt (wake_evt),
    .cfg      (cfg)
  );

  pdseq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_req      (cfg.pd_req),
    .entry_ok    (cfg.entry_ok),
    .cpu_idle    (cpu_idle),
    .any_wake    (any_wake),
    .settle_done (settle_done),
    .state       (state),
    .wake_evt    (wake_evt),
    .settle_run  (settle_run)
  );

  pdseq_timer #(
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wake_evt),
    .long_sel (cfg.long_dly),
    .run      (settle_run),
    .done     (settle_done)
  );

  assign cfg_rd_data = cfg;
  assign pd_active   = (state == ST_DOWN);
  assign sys_clk_en  = (state == ST_RUN) || (state == ST_WAIT_ENTRY);
  assign wake_irq    = cfg.wake_flag && cfg.irq_en;

  initial begin
    assert_cycles_nonzero_R5: assert (SHORT_CYC >= 1 && LONG_CYC >= 1);
  end

  assert_gated_after_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> !sys_clk_en);

  assert_irq_drops_on_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_data[4] && !wake_evt) |=> !wake_irq);

  assert_no_reentry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_run && settle_done) |=> !pd_active);
endmodule

// File: tb/pdseq_top_bench.sv
`timescale 1ns/1ps
module pdseq_top_bench;
  localparam int unsigned REF_HZ = 50_000_000;
  localparam int SHORT_N = 3000;
  localparam int LONG_N  = 10000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [4:0] cfg_wr_data = '0;
  logic [4:0] cfg_rd_data;
  logic       cpu_idle = 1'b0;
  logic       wake_gpio = 1'b0, wake_wdt = 1'b0, wake_rtc = 1'b0;
  logic       sys_clk_en, pd_active, wake_irq;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  pdseq_top #(.REF_HZ(REF_HZ)) u_pdseq_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .cpu_idle(cpu_idle), .wake_gpio(wake_gpio),
    .wake_wdt(wake_wdt), .wake_rtc(wake_rtc), .sys_clk_en(sys_clk_en),
    .pd_active(pd_active), .wake_irq(wake_irq)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0; cfg_wr_data = '0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Arms entry and makes the CPU idle; returns in power-down.
  task automatic enter_down(input logic long_sel, input logic irq_en);
    wr({1'b0, irq_en, long_sel, 1'b1, 1'b1});
    cpu_idle = 1'b1;
    idle_cycles(3);
    check("R2 pd_active after entry", pd_active, 1);
    check("R6 clock gated when down", sys_clk_en, 0);
  endtask

  // Pulses one wake source and counts gated cycles; a second pulse is
  // injected part way through settling when extra_at > 0.
  task automatic wake_and_count(input int src, input int extra_at, output int n);
    case (src)
      0: wake_gpio = 1'b1;
      1: wake_wdt  = 1'b1;
      default: wake_rtc = 1'b1;
    endcase
    @(negedge clk);
    wake_gpio = 1'b0; wake_wdt = 1'b0; wake_rtc = 1'b0;
    cpu_idle = 1'b0;
    n = 0;
    while (!sys_clk_en && n < 20000) begin
      n++;
      if (extra_at > 0 && n == extra_at) wake_rtc = 1'b1;
      @(negedge clk);
      wake_rtc = 1'b0;
    end
  endtask

  task automatic t_reset();
    check("R1 reset control word", cfg_rd_data, 0);
    check("R1 reset clock enable", sys_clk_en, 1);
    check("R1 reset pd_active", pd_active, 0);
    check("R1 reset irq", wake_irq, 0);
  endtask

  task automatic t_unpermitted();
    wr(5'b00001);
    cpu_idle = 1'b1;
    idle_cycles(6);
    check("R3 no entry without permit", pd_active, 0);
    check("R3 clock still running", sys_clk_en, 1);
    cpu_idle = 1'b0;
    wr(5'b00000);
  endtask

  task automatic t_idle_gate();
    wr(5'b00011);
    idle_cycles(6);
    check("R2 no entry while CPU busy", pd_active, 0);
    check("R6 clock runs while waiting", sys_clk_en, 1);
    cpu_idle = 1'b1;
    idle_cycles(2);
    check("R2 entry once idle", pd_active, 1);
    idle_cycles(20);
    check("R4 stays down without wake", pd_active, 1);
  endtask

  task automatic t_short_gpio_irq();
    int n;
    // Already down from t_idle_gate; enable irq is written here via a fresh entry path.
    wake_and_count(0, 0, n);
    check("R5 short settle length", n, SHORT_N);
    check("R7 wake flag set", cfg_rd_data[4], 1);
    check("R7 request cleared by hardware", cfg_rd_data[0], 0);
    check("R9 irq low with enable 0", wake_irq, 0);
    wr(5'b01010);
    check("R9 irq high with flag and enable", wake_irq, 1);
    wr(5'b01010);
    check("R8 write 0 keeps flag", cfg_rd_data[4], 1);
    wr(5'b11010);
    check("R8 write 1 clears flag", cfg_rd_data[4], 0);
    check("R9 irq drops with flag", wake_irq, 0);
  endtask

  task automatic t_long_wdt();
    int n;
    enter_down(1'b1, 1'b1);
    wake_and_count(1, 0, n);
    check("R5 long settle length", n, LONG_N);
    check("R4 watchdog wake flag", cfg_rd_data[4], 1);
    check("R9 irq on wake with enable", wake_irq, 1);
    idle_cycles(3);
    check("R7 no re-entry after release", pd_active, 0);
    wr(5'b10000);
    check("R8 clear flag", cfg_rd_data[4], 0);
  endtask

  task automatic t_rtc_retrigger();
    int n;
    enter_down(1'b0, 1'b0);
    wake_and_count(2, 100, n);
    check("R10 wake in settle does not restart", n, SHORT_N);
    check("R4 rtc wake flag", cfg_rd_data[4], 1);
    wr(5'b10000);
  endtask

  task automatic t_wake_in_run();
    wake_gpio = 1'b1; wake_wdt = 1'b1; wake_rtc = 1'b1;
    @(negedge clk);
    wake_gpio = 1'b0; wake_wdt = 1'b0; wake_rtc = 1'b0;
    idle_cycles(2);
    check("R4 wake in run leaves flag clear", cfg_rd_data[4], 0);
    check("R4 wake in run leaves clock on", sys_clk_en, 1);
  endtask

  initial begin
    idle_cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unpermitted();
    t_idle_gate();
    t_short_gpio_irq();
    t_long_wdt();
    t_rtc_retrigger();
    t_wake_in_run();
    done_flag = 1'b1;
  end

  initial begin
    fork
      wait (done_flag);
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule